// File: doc/BRIEF.md
# Programmable Divided Countdown Timer

This block is a per-core countdown timer with a small register window. Software loads a starting count, picks a clock divider and configures an interrupt entry. Each cycle in which the `bus_tick` enable is high counts as one bus tick. A prescaler turns every N bus ticks into one divided tick, and each divided tick takes one off the live count. When the count reaches zero, the block emits a single-cycle interrupt request that carries an 8-bit vector, unless the entry is masked.

There are two modes. In one-shot mode the timer fires once and then stays idle at zero. In periodic mode it reloads the starting count on the divided tick that follows zero and keeps running. Writing a new starting count re-arms the timer at once. Writing zero stops it.

The register port has no wait states. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `cdt_timer`

## Requirements
- R1: The register window is word-addressed. Address 0 holds the starting count (read/write). Address 1 holds the live count (read-only). Address 2 holds the divider code in bits 3:0. Address 3 holds the interrupt entry: vector in bits 7:0, mask in bit 16, mode in bits 18:17. After reset every register reads 0, except the entry, which reads 0x00010000 (masked).
- R2: The divider code is decoded from bits {3,1,0}. Codes 0x0, 0x1, 0x2 and 0x3 give divide-by-2, 4, 8 and 16. Codes 0x8, 0x9 and 0xA give divide-by-32, 64 and 128. Code 0xB gives divide-by-1.
- R3: Bit 2 of the divider code has no effect on the ratio. Code 0x4 divides like 0x0, and code 0xF divides like 0xB.
- R4: The live count drops by one on every N-th bus tick. A write to the starting count or to the divider clears the prescaler phase, so the first decrement comes on the N-th bus tick after that write.
- R5: A non-zero write to the starting count copies the value into the live count on the same edge and starts counting. A write to address 1 changes nothing.
- R6: Writing zero to the starting count stops the timer. The live count then stays at 0 and no request follows.
- R7: A starting count of 0xFFFFFFFF counts down from that value with no wrap.
- R8: In one-shot mode (mode 00, and also 10 or 11), the request `irq_pulse` is high for exactly one cycle. That cycle is the first one in which the live count reads 0, and `irq_vector` equals the entry vector during it. The count then stays at 0 until the starting count is written again.
- R9: When the mask bit is set, reaching zero raises no request.
- R10: In periodic mode (mode 01), the divided tick after the count reaches 0 reloads the starting count. A request is raised on every pass through zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_tick | input | 1 | One bus tick per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_pulse | output | 1 | Single-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request, zero otherwise |

## Verification
A fault in the prescaler phase shows up as the live count at address 1 being off by one or more after a known number of bus ticks. With divide-by-128 this only becomes visible up to 128 ticks later. This is why every ratio is tested with a tick count one short of a multiple of N. A wrong running flag or wrong mode handling shows within a single divided tick: the count moves after zero when it should hold, or holds when it should reload. The request pulse and its vector are checked on the exact cycle in which the count first reads zero.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int REG_W     = 32;
    localparam int ADDR_W    = 2;
    localparam int VEC_W     = 8;
    localparam int MAX_SHIFT = 7;
    localparam int PHASE_W   = MAX_SHIFT;
    localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);

    localparam logic [ADDR_W-1:0] A_START = 2'd0;
    localparam logic [ADDR_W-1:0] A_LIVE  = 2'd1;
    localparam logic [ADDR_W-1:0] A_DIV   = 2'd2;
    localparam logic [ADDR_W-1:0] A_ENTRY = 2'd3;

    localparam int MASK_BIT = 16;
    localparam int MODE_LO  = 17;

    typedef enum logic [1:0] {
        MODE_ONCE  = 2'b00,
        MODE_REPT  = 2'b01,
        MODE_RSV2  = 2'b10,
        MODE_RSV3  = 2'b11
    } tmode_e;

    typedef struct packed {
        logic [VEC_W-1:0] vector;
        logic             masked;
        tmode_e           mode;
    } entry_t;

    // log2 of the divide ratio; bit 2 of the code plays no part
    function automatic logic [SHIFT_W-1:0] ratio_shift(input logic [3:0] code);
        logic [2:0] sel;
        sel = {code[3], code[1], code[0]};
        if (sel == 3'b111) ratio_shift = '0;
        else               ratio_shift = SHIFT_W'(sel) + SHIFT_W'(1);
    endfunction
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [REG_W-1:0]  live_count,
    output logic [REG_W-1:0]  rdata,
    output logic [REG_W-1:0]  start_count,
    output logic [3:0]        div_code,
    output entry_t            entry,
    output logic              start_wr,
    output logic              div_wr
);
    typedef struct packed {
        logic [REG_W-1:0] start;
        logic [3:0]       div;
        entry_t           ent;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        start_wr = wr && (addr == A_START);
        div_wr   = wr && (addr == A_DIV);
        if (start_wr) r_d.start = wdata;
        if (div_wr)   r_d.div   = wdata[3:0];
        if (wr && (addr == A_ENTRY)) begin
            r_d.ent.vector = wdata[VEC_W-1:0];
            r_d.ent.masked = wdata[MASK_BIT];
            r_d.ent.mode   = tmode_e'(wdata[MODE_LO+1:MODE_LO]);
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_START: rdata = r_q.start;
            A_LIVE:  rdata = live_count;
            A_DIV:   rdata[3:0] = r_q.div;
            A_ENTRY: begin
                rdata[VEC_W-1:0]            = r_q.ent.vector;
                rdata[MASK_BIT]             = r_q.ent.masked;
                rdata[MODE_LO+1:MODE_LO]    = r_q.ent.mode;
            end
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q            <= '0;
            r_q.ent.masked <= 1'b1;
            r_q.ent.mode   <= MODE_ONCE;
        end else begin
            r_q <= r_d;
        end
    end

    assign start_count = r_q.start;
    assign div_code    = r_q.div;
    assign entry       = r_q.ent;
endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
    import cdt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_tick,
    input  logic               clear,
    input  logic [SHIFT_W-1:0] shift,
    output logic               div_tick
);
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
    } ps_t;

    ps_t p_d, p_q;
    logic [PHASE_W:0]   lim_wide;
    logic [PHASE_W-1:0] lim;

    always_comb begin
        lim_wide = ((PHASE_W+1)'(1) << shift) - (PHASE_W+1)'(1);
        lim      = lim_wide[PHASE_W-1:0];
        div_tick = bus_tick && !clear && (p_q.phase == lim);
        p_d      = p_q;
        if (clear)         p_d.phase = '0;
        else if (div_tick) p_d.phase = '0;
        else if (bus_tick) p_d.phase = p_q.phase + PHASE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
    import cdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REG_W-1:0] load_val,
    input  logic [REG_W-1:0] reload_val,
    input  logic             div_tick,
    input  entry_t           entry,
    output logic [REG_W-1:0] count,
    output logic             irq,
    output logic [VEC_W-1:0] irq_vec
);
    typedef struct packed {
        logic [REG_W-1:0] cnt;
        logic             run;
        logic             irq;
        logic [VEC_W-1:0] vec;
    } ctr_t;

    ctr_t c_d, c_q;
    logic periodic;

    always_comb begin
        periodic = (entry.mode == MODE_REPT);
        c_d      = c_q;
        c_d.irq  = 1'b0;
        c_d.vec  = '0;
        if (load) begin
            c_d.cnt = load_val;
            c_d.run = (load_val != '0);
        end else if (c_q.run && div_tick) begin
            if (c_q.cnt == '0) begin
                if (periodic) c_d.cnt = reload_val;
                else          c_d.run = 1'b0;
            end else begin
                c_d.cnt = c_q.cnt - REG_W'(1);
                if (c_q.cnt == REG_W'(1)) begin
                    c_d.irq = !entry.masked;
                    c_d.vec = entry.masked ? '0 : entry.vector;
                    if (!periodic) c_d.run = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count   = c_q.cnt;
    assign irq     = c_q.irq;
    assign irq_vec = c_q.vec;
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_pulse,
    output logic [VEC_W-1:0]  irq_vector
);
    logic [REG_W-1:0]   cur_count;
    logic [REG_W-1:0]   start_count;
    logic [3:0]         div_code;
    entry_t             entry;
    logic               start_wr;
    logic               div_wr;
    logic               div_tick;
    logic               lvt_masked;
    logic [SHIFT_W-1:0] shift;

    assign shift      = ratio_shift(div_code);
    assign lvt_masked = entry.masked;

    cdt_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (reg_wr),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .live_count  (cur_count),
        .rdata       (reg_rdata),
        .start_count (start_count),
        .div_code    (div_code),
        .entry       (entry),
        .start_wr    (start_wr),
        .div_wr      (div_wr)
    );

    cdt_prescaler u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_tick (bus_tick),
        .clear    (start_wr || div_wr),
        .shift    (shift),
        .div_tick (div_tick)
    );

    cdt_counter u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start_wr),
        .load_val   (reg_wdata),
        .reload_val (start_count),
        .div_tick   (div_tick),
        .entry      (entry),
        .count      (cur_count),
        .irq        (irq_pulse),
        .irq_vec    (irq_vector)
    );
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk
    import cdt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  cur_count,
    input logic              lvt_masked,
    input logic              irq_pulse
);
    logic start_w;
    assign start_w = reg_wr && (reg_addr == A_START);

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    assert_irq_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (cur_count == '0));

    assert_mask_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> !$past(lvt_masked));

    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> (cur_count == $past(reg_wdata)));

    assert_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_w && reg_wdata == '0) |=> (cur_count == '0 && !irq_pulse));

    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_w && cur_count != '0) |=> (cur_count <= $past(cur_count)));

    assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_w && cur_count != '0) |=>
            (cur_count == $past(cur_count) || cur_count == $past(cur_count) - REG_W'(1)));
endmodule

bind cdt_timer cdt_timer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .cur_count  (cur_count),
    .lvt_masked (lvt_masked),
    .irq_pulse  (irq_pulse)
);

// File: tb/tb_cdt_timer.sv
`timescale 1ns/1ps
module tb_cdt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_pulse;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cdt_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        bus_tick = 1'b1;
        repeat (n) @(negedge clk);
        bus_tick = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(2'd0, v); check("R1 start reset", v, 32'h0);
        rd(2'd1, v); check("R1 live reset", v, 32'h0);
        rd(2'd2, v); check("R1 div reset", v, 32'h0);
        rd(2'd3, v); check("R1 entry reset", v, 32'h0001_0000);
        check("R1 irq reset", {31'b0, irq_pulse}, 32'h0);
    endtask

    task automatic t_ratio(input logic [3:0] code, input int n, input string req);
        logic [31:0] v;
        wr(2'd0, 32'd0);
        wr(2'd2, {28'b0, code});
        wr(2'd0, 32'd1000);
        ticks(4*n - 1);
        rd(2'd1, v);
        check(req, v, 32'd997);
    endtask

    task automatic t_ratios;
        t_ratio(4'h0, 2,   "R2 code0");
        t_ratio(4'h1, 4,   "R2 code1");
        t_ratio(4'h2, 8,   "R2 code2");
        t_ratio(4'h3, 16,  "R2 code3");
        t_ratio(4'h8, 32,  "R2 code8");
        t_ratio(4'h9, 64,  "R2 code9");
        t_ratio(4'hA, 128, "R2 codeA");
        t_ratio(4'hB, 1,   "R2 codeB");
        t_ratio(4'h4, 2,   "R3 code4");
        t_ratio(4'hF, 1,   "R3 codeF");
    endtask

    task automatic t_phase_R4;
        logic [31:0] v;
        wr(2'd0, 32'd0);
        wr(2'd2, 32'h2);
        wr(2'd0, 32'd100);
        ticks(5);
        wr(2'd2, 32'h1);
        ticks(3);
        rd(2'd1, v); check("R4 no step before N", v, 32'd100);
        ticks(1);
        rd(2'd1, v); check("R4 step at N", v, 32'd99);
    endtask

    task automatic t_load_R5;
        logic [31:0] v;
        wr(2'd2, 32'hB);
        wr(2'd0, 32'd50);
        rd(2'd1, v); check("R5 load", v, 32'd50);
        ticks(2);
        wr(2'd0, 32'd7);
        rd(2'd1, v); check("R5 rearm", v, 32'd7);
        wr(2'd1, 32'd123);
        rd(2'd1, v); check("R5 live write ignored", v, 32'd7);
        rd(2'd0, v); check("R5 start unchanged", v, 32'd7);
    endtask

    task automatic t_stop_R6;
        logic [31:0] v;
        int pulses = 0;
        wr(2'd3, 32'h0000_0011);
        wr(2'd0, 32'd20);
        ticks(3);
        wr(2'd0, 32'd0);
        rd(2'd1, v); check("R6 stopped zero", v, 32'd0);
        bus_tick = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (irq_pulse) pulses++;
        end
        bus_tick = 1'b0;
        rd(2'd1, v); check("R6 stays zero", v, 32'd0);
        check("R6 no request", pulses, 0);
    endtask

    task automatic t_max_R7;
        logic [31:0] v;
        wr(2'd3, 32'h0001_0000);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd1, v); check("R7 max load", v, 32'hFFFF_FFFF);
        ticks(5);
        rd(2'd1, v); check("R7 no wrap", v, 32'hFFFF_FFFA);
        wr(2'd0, 32'd0);
    endtask

    task automatic t_oneshot_R8;
        logic [31:0] v;
        int pulses = 0;
        int at = -1;
        logic [7:0] vec = 8'h00;
        wr(2'd3, 32'h0000_005A);
        bus_tick = 1'b1;
        wr(2'd0, 32'd3);
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (irq_pulse) begin pulses++; at = k; vec = irq_vector; end
        end
        bus_tick = 1'b0;
        check("R8 one pulse", pulses, 1);
        check("R8 pulse cycle", at, 3);
        check("R8 vector", {24'b0, vec}, 32'h5A);
        rd(2'd1, v); check("R8 holds zero", v, 32'd0);
    endtask

    task automatic t_mask_R9;
        logic [31:0] v;
        int pulses = 0;
        wr(2'd3, 32'h0001_005A);
        bus_tick = 1'b1;
        wr(2'd0, 32'd3);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (irq_pulse) pulses++;
        end
        bus_tick = 1'b0;
        check("R9 masked silent", pulses, 0);
        rd(2'd1, v); check("R9 count reached zero", v, 32'd0);
    endtask

    task automatic t_periodic_R10;
        logic [31:0] v;
        int pulses = 0;
        wr(2'd3, 32'h0002_0033);
        bus_tick = 1'b1;
        wr(2'd0, 32'd2);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (irq_pulse) pulses++;
            if (k == 3) begin rd(2'd1, v); check("R10 reload", v, 32'd2); end
        end
        bus_tick = 1'b0;
        check("R10 pulse count", pulses, 3);
        wr(2'd0, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_ratios;
        t_phase_R4;
        t_load_R5;
        t_stop_R6;
        t_max_R7;
        t_oneshot_R8;
        t_mask_R9;
        t_periodic_R10;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule